// File: doc/BRIEF.md
# Video Controller CPU Register Front End

This block sits between the host processor bus and a tile-based video controller. It decodes eight byte-wide register slots, holds the control, mask, scroll, sprite-address and video-address state, and keeps the read-ahead buffer for the video-memory data port. It also keeps the write-pairing toggle that the scroll and address ports share, the vertical-blank flag and the odd-frame flag. Raster timing lives elsewhere. That logic tells this block when vertical blank starts (`vbl_start`) and when the frame wraps (`frame_end`).

Two kinds of initialisation are handled. The synchronous `rst` input is a cold power-on. `warm_rst` is a warm reset, which clears only part of the state. A parameter selects a variant in which the warm reset is disconnected. After power-on, a warm-up counter locks out writes to the timing-sensitive registers. A status read that lands in the same cycle as the vertical-blank start returns the flag as 0 and cancels the flag for that frame.

Top module: `vid_regfront`

## Requirements
- R1: After `rst`, the following all read as zero: `ctrl_q`, `mask_q`, `scroll_q`, `oam_addr`, the video address on `mem_addr`, the read buffer, the write toggle and `odd_frame`. The vertical-blank flag is 1.
- R2: A warm reset clears control, mask, scroll, the write toggle, the read buffer and `odd_frame`.
- R3: A warm reset leaves `oam_addr`, the video address and the vertical-blank flag unchanged.
- R4: With `IGNORE_WARM`=1, `warm_rst` changes no state at all.
- R5: Reading slot 2 (status) returns bit 7 as the vertical-blank flag, bits 6:5 as 0 and bits 4:0 as the low bits of the last CPU write. After the read, the flag and the write toggle are cleared.
- R6: A status read in the same cycle as `vbl_start` returns bit 7 as 0, and the flag stays 0 afterwards.
- R7: `nmi` is high exactly while the vertical-blank flag is set and control bit 7 is 1. Setting bit 7 while the flag is set raises `nmi` on the next cycle.
- R8: Reading slot 7 returns the old buffer contents, then loads the buffer from `mem_rdata` at the current address. The address then advances by 1, or by 32 when control bit 2 is set. A write to slot 7 also advances the address.
- R9: Writes to slots 0, 1, 5 and 6 are ignored until `WARMUP` cycles have elapsed since power-on. Slots 3, 4 and 7 are never locked.
- R10: On slot 6, the first write of a pair supplies address bits 13:8 from data bits 5:0. The second write supplies bits 7:0 and loads the video address. On slot 5, the first write sets X and the second sets Y; `scroll_q` is {Y, X}. Each write flips the shared toggle.
- R11: `frame_end` clears the vertical-blank flag and inverts `odd_frame`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Power-on reset, synchronous, active high |
| warm_rst | input | 1 | Warm reset, synchronous, active high |
| cpu_sel | input | 1 | Register access this cycle |
| cpu_we | input | 1 | 1 for a write, 0 for a read |
| cpu_addr | input | 3 | Register slot |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data, valid in the access cycle |
| vbl_start | input | 1 | Pulse at the start of vertical blank |
| frame_end | input | 1 | Pulse at the end of a frame |
| mem_addr | output | 14 | Current video address |
| mem_rdata | input | 8 | Video memory data at `mem_addr` |
| mem_rd | output | 1 | Data-port read this cycle |
| mem_we | output | 1 | Data-port write this cycle |
| mem_wdata | output | 8 | Data-port write data |
| ctrl_q | output | 8 | Control register |
| mask_q | output | 8 | Mask register |
| scroll_q | output | 16 | Scroll, {Y, X} |
| oam_addr | output | 8 | Sprite memory address |
| odd_frame | output | 1 | Odd-frame flag |
| nmi | output | 1 | Interrupt request |

## Verification
Two instances run side by side on the same stimulus, one honouring the warm reset and one ignoring it. A single warm reset therefore shows which registers are cleared, which are kept and which are untouched. Status is read in three situations, each separating a different fault:
- with the flag set, which checks that the flag is reported;
- straight after a lone scroll write, which checks that the toggle is cleared;
- in the `vbl_start` cycle, which checks that the race both reads 0 and cancels the flag.

The data port is read before and after the increment size changes, which distinguishes the buffered return from a direct return and a step of 1 from a step of 32. Control writes issued before and after warm-up expiry show the lockout.

// File: rtl/vrf_pkg.sv
package vrf_pkg;
    localparam int DATA_W  = 8;
    localparam int VADDR_W = 14;

    typedef enum logic [2:0] {
        SLOT_CTRL = 3'd0,
        SLOT_MASK = 3'd1,
        SLOT_STAT = 3'd2,
        SLOT_OADR = 3'd3,
        SLOT_ODAT = 3'd4,
        SLOT_SCRL = 3'd5,
        SLOT_ADDR = 3'd6,
        SLOT_DATA = 3'd7
    } slot_e;

    typedef struct packed {
        logic [DATA_W-1:0] ctrl;
        logic [DATA_W-1:0] mask;
        logic [DATA_W-1:0] scr_y;
        logic [DATA_W-1:0] scr_x;
    } view_regs_t;

    localparam int CTRL_NMI_BIT  = 7;
    localparam int CTRL_WIDE_BIT = 2;

    function automatic logic [VADDR_W-1:0] vaddr_step(input logic [VADDR_W-1:0] a,
                                                      input logic wide);
        return a + (wide ? VADDR_W'(32) : VADDR_W'(1));
    endfunction

    function automatic logic slot_locked(input slot_e s);
        return (s == SLOT_CTRL) || (s == SLOT_MASK) || (s == SLOT_SCRL) || (s == SLOT_ADDR);
    endfunction
endpackage

// File: rtl/vrf_warmup.sv
module vrf_warmup #(
    parameter int WARMUP = 29658
) (
    input  logic clk,
    input  logic rst,
    output logic ready
);
    localparam int CW = $clog2(WARMUP + 1);

    logic [CW-1:0] cnt;

    assign ready = (cnt == CW'(WARMUP));

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (!ready)
            cnt <= cnt + 1'b1;
    end

    // R9: once unlocked, the lock never returns without power-on
    p_ready_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        ready |=> ready);
endmodule

// File: rtl/vrf_vblank.sv
module vrf_vblank (
    input  logic clk,
    input  logic rst,
    input  logic warm,
    input  logic vbl_start,
    input  logic frame_end,
    input  logic stat_rd,
    output logic vbl_flag,
    output logic stat_bit7,
    output logic odd_frame
);
    // race: a read landing on the set cycle sees 0
    assign stat_bit7 = vbl_flag && !vbl_start;

    always_ff @(posedge clk) begin
        if (rst) begin
            vbl_flag  <= 1'b1;
            odd_frame <= 1'b0;
        end else if (warm) begin
            odd_frame <= 1'b0;
        end else begin
            if (stat_rd)
                vbl_flag <= 1'b0;
            else if (vbl_start)
                vbl_flag <= 1'b1;
            else if (frame_end)
                vbl_flag <= 1'b0;
            if (frame_end)
                odd_frame <= !odd_frame;
        end
    end

    p_race_cancel_r6: assert property (@(posedge clk) disable iff (rst)
        (stat_rd && vbl_start && !warm) |=> !vbl_flag);
    p_read_clears_r5: assert property (@(posedge clk) disable iff (rst)
        (stat_rd && !warm) |=> !vbl_flag);
    p_warm_keeps_flag_r3: assert property (@(posedge clk) disable iff (rst)
        warm |=> vbl_flag == $past(vbl_flag));
endmodule

// File: rtl/vrf_regfile.sv
module vrf_regfile
    import vrf_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               warm,
    input  logic               ready,
    input  logic               sel,
    input  logic               we,
    input  slot_e              slot,
    input  logic [DATA_W-1:0]  wdata,
    input  logic               stat_bit7,
    input  logic [DATA_W-1:0]  mem_rdata,
    output logic [DATA_W-1:0]  rdata,
    output logic               stat_rd,
    output logic               mem_rd,
    output logic               mem_we,
    output logic [VADDR_W-1:0] vaddr,
    output view_regs_t         regs,
    output logic [DATA_W-1:0]  oam_addr
);
    logic                  toggle;
    logic [VADDR_W-9:0]    addr_hi;
    logic [DATA_W-1:0]     rbuf;
    logic [DATA_W-1:0]     latch;
    logic                  acc, wr_ok;

    assign acc     = sel && !warm;
    assign wr_ok   = ready || !slot_locked(slot);
    assign stat_rd = acc && !we && (slot == SLOT_STAT);
    assign mem_rd  = acc && !we && (slot == SLOT_DATA);
    assign mem_we  = acc && we && (slot == SLOT_DATA);

    always_comb begin
        case (slot)
            SLOT_STAT: rdata = {stat_bit7, 2'b00, latch[4:0]};
            SLOT_DATA: rdata = rbuf;
            default:   rdata = latch;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            regs     <= '0;
            oam_addr <= '0;
            vaddr    <= '0;
            addr_hi  <= '0;
            toggle   <= 1'b0;
            rbuf     <= '0;
            latch    <= '0;
        end else if (warm) begin
            regs   <= '0;
            toggle <= 1'b0;
            rbuf   <= '0;
        end else if (acc && we) begin
            latch <= wdata;
            if (wr_ok) begin
                case (slot)
                    SLOT_CTRL: regs.ctrl <= wdata;
                    SLOT_MASK: regs.mask <= wdata;
                    SLOT_OADR: oam_addr  <= wdata;
                    SLOT_ODAT: oam_addr  <= oam_addr + 1'b1;
                    SLOT_SCRL: begin
                        if (toggle) regs.scr_y <= wdata;
                        else        regs.scr_x <= wdata;
                        toggle <= !toggle;
                    end
                    SLOT_ADDR: begin
                        if (toggle) vaddr   <= {addr_hi, wdata};
                        else        addr_hi <= wdata[VADDR_W-9:0];
                        toggle <= !toggle;
                    end
                    SLOT_DATA: vaddr <= vaddr_step(vaddr, regs.ctrl[CTRL_WIDE_BIT]);
                    default: ;
                endcase
            end
        end else if (acc) begin
            if (slot == SLOT_STAT)
                toggle <= 1'b0;
            if (slot == SLOT_DATA) begin
                rbuf  <= mem_rdata;
                vaddr <= vaddr_step(vaddr, regs.ctrl[CTRL_WIDE_BIT]);
            end
        end
    end

    p_warm_clears_r2: assert property (@(posedge clk) disable iff (rst)
        warm |=> (regs == '0) && !toggle && (rbuf == '0));
    p_warm_keeps_addr_r3: assert property (@(posedge clk) disable iff (rst)
        warm |=> (oam_addr == $past(oam_addr)) && (vaddr == $past(vaddr)));
    p_locked_ctrl_r9: assert property (@(posedge clk) disable iff (rst)
        !ready |=> regs.ctrl == $past(regs.ctrl));
    p_buffer_loads_r8: assert property (@(posedge clk) disable iff (rst)
        mem_rd |=> rbuf == $past(mem_rdata));
endmodule

// File: rtl/vid_regfront.sv
module vid_regfront
    import vrf_pkg::*;
#(
    parameter int WARMUP      = 29658,
    parameter bit IGNORE_WARM = 1'b0
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               warm_rst,
    input  logic               cpu_sel,
    input  logic               cpu_we,
    input  logic [2:0]         cpu_addr,
    input  logic [DATA_W-1:0]  cpu_wdata,
    output logic [DATA_W-1:0]  cpu_rdata,
    input  logic               vbl_start,
    input  logic               frame_end,
    output logic [VADDR_W-1:0] mem_addr,
    input  logic [DATA_W-1:0]  mem_rdata,
    output logic               mem_rd,
    output logic               mem_we,
    output logic [DATA_W-1:0]  mem_wdata,
    output logic [DATA_W-1:0]  ctrl_q,
    output logic [DATA_W-1:0]  mask_q,
    output logic [2*DATA_W-1:0] scroll_q,
    output logic [DATA_W-1:0]  oam_addr,
    output logic               odd_frame,
    output logic               nmi
);
    logic       warm, ready, stat_rd, stat_bit7, vbl_flag;
    view_regs_t regs;

    generate
        if (IGNORE_WARM) begin : g_nowarm
            assign warm = 1'b0;
        end else begin : g_warm
            assign warm = warm_rst;
        end
    endgenerate

    vrf_warmup #(.WARMUP(WARMUP)) u_warmup (
        .clk(clk), .rst(rst), .ready(ready)
    );

    vrf_vblank u_vblank (
        .clk(clk), .rst(rst), .warm(warm), .vbl_start(vbl_start),
        .frame_end(frame_end), .stat_rd(stat_rd), .vbl_flag(vbl_flag),
        .stat_bit7(stat_bit7), .odd_frame(odd_frame)
    );

    vrf_regfile u_regfile (
        .clk(clk), .rst(rst), .warm(warm), .ready(ready), .sel(cpu_sel),
        .we(cpu_we), .slot(slot_e'(cpu_addr)), .wdata(cpu_wdata),
        .stat_bit7(stat_bit7), .mem_rdata(mem_rdata), .rdata(cpu_rdata),
        .stat_rd(stat_rd), .mem_rd(mem_rd), .mem_we(mem_we), .vaddr(mem_addr),
        .regs(regs), .oam_addr(oam_addr)
    );

    assign mem_wdata = cpu_wdata;
    assign ctrl_q    = regs.ctrl;
    assign mask_q    = regs.mask;
    assign scroll_q  = {regs.scr_y, regs.scr_x};
    assign nmi       = vbl_flag && regs.ctrl[CTRL_NMI_BIT];

    // R7: a status read drops the interrupt on the following cycle
    p_nmi_drop_r7: assert property (@(posedge clk) disable iff (rst)
        (stat_rd && !warm) |=> !nmi);
endmodule

// File: tb/vid_regfront_bench.sv
module vid_regfront_bench;
    localparam int WARMUP = 29658;

    logic clk = 1'b0;
    logic rst = 1'b1, warm_rst = 1'b0;
    logic sel = 1'b0, we = 1'b0;
    logic [2:0] addr = '0;
    logic [7:0] wdata = '0;
    logic vbl_start = 1'b0, frame_end = 1'b0;

    logic [7:0]  rdata, ctrl, mask, oam, rdata2, ctrl2, mask2, oam2, md1, md2, mwd1, mwd2;
    logic [13:0] maddr, maddr2;
    logic [15:0] scroll, scroll2;
    logic odd, nmi, odd2, nmi2, mrd1, mwe1, mrd2, mwe2;

    always #4 clk = !clk;

    assign md1 = maddr[7:0] ^ 8'hA5;
    assign md2 = maddr2[7:0] ^ 8'hA5;

    vid_regfront #(.WARMUP(WARMUP), .IGNORE_WARM(1'b0)) u_vid_regfront (
        .clk(clk), .rst(rst), .warm_rst(warm_rst), .cpu_sel(sel), .cpu_we(we),
        .cpu_addr(addr), .cpu_wdata(wdata), .cpu_rdata(rdata), .vbl_start(vbl_start),
        .frame_end(frame_end), .mem_addr(maddr), .mem_rdata(md1), .mem_rd(mrd1),
        .mem_we(mwe1), .mem_wdata(mwd1), .ctrl_q(ctrl), .mask_q(mask),
        .scroll_q(scroll), .oam_addr(oam), .odd_frame(odd), .nmi(nmi));

    vid_regfront #(.WARMUP(WARMUP), .IGNORE_WARM(1'b1)) u_vid_regfront_nowarm (
        .clk(clk), .rst(rst), .warm_rst(warm_rst), .cpu_sel(sel), .cpu_we(we),
        .cpu_addr(addr), .cpu_wdata(wdata), .cpu_rdata(rdata2), .vbl_start(vbl_start),
        .frame_end(frame_end), .mem_addr(maddr2), .mem_rdata(md2), .mem_rd(mrd2),
        .mem_we(mwe2), .mem_wdata(mwd2), .ctrl_q(ctrl2), .mask_q(mask2),
        .scroll_q(scroll2), .oam_addr(oam2), .odd_frame(odd2), .nmi(nmi2));

    typedef enum int {W_RDATA, W_CTRL, W_MASK, W_OAM, W_MADDR, W_SCROLL, W_NMI, W_ODD,
                      W_CTRL2, W_MASK2, W_ODD2, W_NMI2} what_e;
    typedef struct { what_e what; int exp; string req; } item_t;

    item_t q[$];
    int total = 0, bad = 0;
    bit finished = 0;

    function automatic int actual(what_e w);
        case (w)
            W_RDATA:  return int'(rdata);
            W_CTRL:   return int'(ctrl);
            W_MASK:   return int'(mask);
            W_OAM:    return int'(oam);
            W_MADDR:  return int'(maddr);
            W_SCROLL: return int'(scroll);
            W_NMI:    return int'(nmi);
            W_ODD:    return int'(odd);
            W_CTRL2:  return int'(ctrl2);
            W_MASK2:  return int'(mask2);
            W_ODD2:   return int'(odd2);
            default:  return int'(nmi2);
        endcase
    endfunction

    // monitor: pops expected items and compares against the ports
    initial begin
        forever begin
            wait (q.size() > 0);
            #1;
            while (q.size() > 0) begin
                item_t it;
                it = q.pop_front();
                total++;
                if (actual(it.what) != it.exp) begin
                    bad++;
                    $display("FAIL %s %s: actual=0x%0h expected=0x%0h",
                             it.req, it.what.name(), actual(it.what), it.exp);
                end
            end
        end
    end

    task automatic expect_val(what_e w, int e, string r);
        item_t it;
        it.what = w; it.exp = e; it.req = r;
        q.push_back(it);
    endtask

    task automatic settle();
        @(negedge clk);
        #2;
    endtask

    task automatic wr(logic [2:0] a, logic [7:0] d);
        @(negedge clk);
        sel = 1'b1; we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        sel = 1'b0; we = 1'b0;
    endtask

    task automatic rd(logic [2:0] a, int e, string r, bit with_vbl);
        @(negedge clk);
        sel = 1'b1; we = 1'b0; addr = a; vbl_start = with_vbl;
        expect_val(W_RDATA, e, r);
        #2;
        @(negedge clk);
        sel = 1'b0; vbl_start = 1'b0;
    endtask

    task automatic pulse_vbl();
        @(negedge clk); vbl_start = 1'b1;
        @(negedge clk); vbl_start = 1'b0;
    endtask

    task automatic pulse_frame_end();
        @(negedge clk); frame_end = 1'b1;
        @(negedge clk); frame_end = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        settle();
        // R1 power-on state
        expect_val(W_CTRL, 0, "R1"); expect_val(W_MASK, 0, "R1");
        expect_val(W_OAM, 0, "R1");  expect_val(W_MADDR, 0, "R1");
        expect_val(W_SCROLL, 0, "R1"); expect_val(W_ODD, 0, "R1");
        rd(3'd2, 8'h80, "R1_R5 flag set at power-on", 1'b0);
        rd(3'd2, 8'h00, "R5 flag cleared by read", 1'b0);

        // R9 lockout before warm-up expiry
        wr(3'd0, 8'h80);
        wr(3'd3, 8'h10);
        settle();
        expect_val(W_CTRL, 0, "R9 ctrl write locked");
        expect_val(W_OAM, 8'h10, "R9 sprite addr not locked");
        repeat (WARMUP + 20) @(negedge clk);
        wr(3'd0, 8'h80);
        settle();
        expect_val(W_CTRL, 8'h80, "R9 ctrl write after warm-up");

        // R7 interrupt, R11 frame end
        pulse_vbl();
        settle(); expect_val(W_NMI, 1, "R7 nmi on vblank");
        wr(3'd0, 8'h00);
        settle(); expect_val(W_NMI, 0, "R7 nmi disabled");
        wr(3'd0, 8'h80);
        settle(); expect_val(W_NMI, 1, "R7 nmi immediate on enable");
        pulse_frame_end();
        settle();
        expect_val(W_NMI, 0, "R11 flag cleared");
        expect_val(W_ODD, 1, "R11 odd toggles");

        // R10 address pair, R8 buffered data port
        wr(3'd6, 8'h21); wr(3'd6, 8'h08);
        settle(); expect_val(W_MADDR, 14'h2108, "R10 address pair");
        rd(3'd7, 8'h00, "R8 first read returns buffer", 1'b0);
        rd(3'd7, 8'hAD, "R8 buffered data", 1'b0);
        wr(3'd0, 8'h84);
        rd(3'd7, 8'hAC, "R8 buffered data", 1'b0);
        settle(); expect_val(W_MADDR, 14'h212A, "R8 step by 32");

        // R5 status read clears toggle; R10 scroll pairing
        wr(3'd5, 8'h11);
        rd(3'd2, 8'h11, "R5 low bits from last write", 1'b0);
        wr(3'd5, 8'h22); wr(3'd5, 8'h33);
        settle(); expect_val(W_SCROLL, 16'h3322, "R5_R10 toggle cleared, scroll pair");

        // R6 race
        rd(3'd2, 8'h13, "R6 race read returns 0", 1'b1);
        rd(3'd2, 8'h13, "R6 flag cancelled", 1'b0);

        // R2, R3, R4 warm reset
        pulse_vbl();
        wr(3'd1, 8'h1E);
        wr(3'd5, 8'h44);
        settle(); expect_val(W_NMI, 1, "R3 flag set before warm reset");
        @(negedge clk); warm_rst = 1'b1;
        @(negedge clk); warm_rst = 1'b0;
        #2;
        expect_val(W_CTRL, 0, "R2"); expect_val(W_MASK, 0, "R2");
        expect_val(W_SCROLL, 0, "R2"); expect_val(W_ODD, 0, "R2");
        expect_val(W_OAM, 8'h10, "R3"); expect_val(W_MADDR, 14'h212A, "R3");
        expect_val(W_CTRL2, 8'h84, "R4"); expect_val(W_MASK2, 8'h1E, "R4");
        expect_val(W_ODD2, 1, "R4"); expect_val(W_NMI2, 1, "R4");
        wr(3'd5, 8'h55);
        settle(); expect_val(W_SCROLL, 16'h0055, "R2 toggle cleared");
        rd(3'd7, 8'h00, "R2 read buffer cleared", 1'b0);
        rd(3'd2, 8'h95, "R3 flag kept", 1'b0);

        settle();
        #4;
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(8 * 200000);
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule